// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a virtual address into a physical address when the translation cache misses. It takes one request at a time, reads a first-level descriptor from a translation table in memory, and either finishes there or follows a pointer to a second-level table and reads a second descriptor. The outcome is either a translation (physical address, page-size code and three memory attributes) or a translation fault that holds the faulting virtual address until software acknowledges it.

Memory is reached through a simple read port. The walker raises `mem_req` for one cycle with a word address. The memory answers some cycles later with `mem_rsp_valid` and the descriptor word. There is no back-pressure on the read port, and only one read is outstanding at any time. First-level descriptors can describe a 1 MB block or a 16 MB block. Second-level descriptors can describe a 4 KB page or a 64 KB page. Each 16 MB or 64 KB mapping is stored as sixteen identical descriptors, so the walker reads the copy that the virtual address selects and needs no special handling.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req`, `res_valid` and `fault_valid` are 0.
- R2: One cycle after a request is accepted, `mem_req` is high for exactly one cycle with `mem_addr` = {tbl_base[31:14], va[31:20], 2'b00}. Bits [13:0] of `tbl_base` have no effect on this address.
- R3: A first-level descriptor with bits [1:0] = 2 and bit 18 = 0 gives `res_size` = 2 (1 MB) and `res_pa` = {desc[31:20], va[19:0]}.
- R4: A first-level descriptor with bits [1:0] = 2 and bit 18 = 1 gives `res_size` = 3 (16 MB) and `res_pa` = {desc[31:24], va[23:0]}.
- R5: For a first-level block, `res_endian` = desc[15], `res_elem` = desc[11:10] and `res_mixed` = desc[17].
- R6: A first-level descriptor with bits [1:0] = 1 causes a second read, one cycle after its response, at {desc[31:10], va[19:12], 2'b00}. This read is again a one-cycle `mem_req`.
- R7: A second-level descriptor with bits [1:0] = 2 gives `res_size` = 0 (4 KB) and `res_pa` = {desc[31:12], va[11:0]}. Bits [1:0] = 1 give `res_size` = 1 (64 KB) and `res_pa` = {desc[31:16], va[15:0]}.
- R8: For a second-level page, `res_endian` = desc[9], `res_elem` = desc[5:4] and `res_mixed` = desc[11].
- R9: A descriptor with bits [1:0] equal to 0, or equal to 3 at either level, produces no result. Instead `fault_valid` rises, with `fault_va` set to the walked address and `fault_stat` = 1 for a first-level fault or 2 for a second-level fault. Both stay unchanged until `fault_ack`, after which `fault_valid` is 0.
- R10: `req_ready` is 0 from the cycle after acceptance until the walk has produced its result or its fault has been acknowledged. A request offered in that time is ignored: no extra memory read is issued, and the result of the walk in progress is unchanged.
- R11: `res_valid` is a one-cycle pulse. It is high in the cycle after the response carrying the final descriptor, and `res_valid` and `fault_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| tbl_base | input | 32 | First-level table base, sampled at acceptance |
| mem_req | output | 1 | One-cycle descriptor read request |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Descriptor word returned |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Translation result pulse |
| res_pa | output | 32 | Physical address |
| res_size | output | 2 | 0=4 KB, 1=64 KB, 2=1 MB, 3=16 MB |
| res_endian | output | 1 | Endianness attribute |
| res_elem | output | 2 | Element-size attribute |
| res_mixed | output | 1 | Mixed-size attribute |
| fault_valid | output | 1 | Translation fault pending |
| fault_va | output | 32 | Virtual address of the faulting walk |
| fault_stat | output | 2 | 1 = first-level fault, 2 = second-level fault |
| fault_ack | input | 1 | Clears a pending fault |

## Verification
Each result has a fixed due cycle. The first read appears in the cycle after acceptance. A second-level read appears in the cycle after the first response. The result pulse or the fault appears in the cycle after the final response, and an acknowledged fault clears in the following cycle. The bench plays the memory itself and drives every input on the falling edge. It then samples each output at exactly the falling edge where that output is due, and at the one after, to confirm that pulses end and held faults stay. Response latency is varied from one to three cycles, and competing requests are offered while a walk is in progress.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int unsigned AW       = 32;
  localparam int unsigned L1_IDX_W = 12;
  localparam int unsigned L2_IDX_W = 8;
  localparam int unsigned L1_ALIGN = 14;
  localparam int unsigned L2_ALIGN = 10;
  localparam int unsigned SZ_W     = 2;
  localparam int unsigned ELEM_W   = 2;
  localparam int unsigned SHIFT_MIN = 12;
  localparam int unsigned SHIFT_STEP = 4;

  typedef logic [AW-1:0] word_t;

  typedef enum logic [SZ_W-1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pgsz_e;

  typedef enum logic [1:0] {
    FS_NONE = 2'd0,
    FS_LVL1 = 2'd1,
    FS_LVL2 = 2'd2
  } fstat_e;

  typedef enum logic [1:0] {
    DK_FAULT = 2'd0,
    DK_LEAF  = 2'd1,
    DK_TABLE = 2'd2
  } dkind_e;

  typedef struct packed {
    logic              endian;
    logic [ELEM_W-1:0] elem;
    logic              mixed;
  } attr_t;

  function automatic word_t l1_addr(input word_t base, input word_t va);
    word_t a;
    a = '0;
    a[AW-1:L1_ALIGN] = base[AW-1:L1_ALIGN];
    a[L1_ALIGN-1:2]  = va[AW-1:AW-L1_IDX_W];
    return a;
  endfunction

  function automatic word_t l2_addr(input word_t desc, input word_t va);
    word_t a;
    a = '0;
    a[AW-1:L2_ALIGN] = desc[AW-1:L2_ALIGN];
    a[L2_ALIGN-1:2]  = va[AW-L1_IDX_W-1:AW-L1_IDX_W-L2_IDX_W];
    return a;
  endfunction

  // page offset width grows by four bits per size code step
  function automatic int unsigned page_shift(input pgsz_e sz);
    return SHIFT_MIN + SHIFT_STEP * int'(sz);
  endfunction

  function automatic word_t merge_pa(input word_t desc, input word_t va, input pgsz_e sz);
    word_t m;
    m = (word_t'(1) << page_shift(sz)) - word_t'(1);
    return (desc & ~m) | (va & m);
  endfunction

  function automatic attr_t attr_lvl1(input word_t d);
    attr_t r;
    r.endian = d[15];
    r.elem   = d[11:10];
    r.mixed  = d[17];
    return r;
  endfunction

  function automatic attr_t attr_lvl2(input word_t d);
    attr_t r;
    r.endian = d[9];
    r.elem   = d[5:4];
    r.mixed  = d[11];
    return r;
  endfunction
endpackage

// File: rtl/xw_l1_decode.sv
module xw_l1_decode
  import xw_pkg::*;
(
  input  word_t  desc,
  input  word_t  va,
  output dkind_e kind,
  output pgsz_e  size,
  output attr_t  attr,
  output word_t  pa,
  output word_t  next_addr
);
  always_comb begin
    size = desc[18] ? PG_16M : PG_1M;
    unique case (desc[1:0])
      2'd2:    kind = DK_LEAF;
      2'd1:    kind = DK_TABLE;
      default: kind = DK_FAULT;
    endcase
  end

  assign attr      = attr_lvl1(desc);
  assign pa        = merge_pa(desc, va, size);
  assign next_addr = l2_addr(desc, va);
endmodule

// File: rtl/xw_l2_decode.sv
module xw_l2_decode
  import xw_pkg::*;
(
  input  word_t  desc,
  input  word_t  va,
  output dkind_e kind,
  output pgsz_e  size,
  output attr_t  attr,
  output word_t  pa
);
  always_comb begin
    unique case (desc[1:0])
      2'd2: begin kind = DK_LEAF;  size = PG_4K;  end
      2'd1: begin kind = DK_LEAF;  size = PG_64K; end
      default: begin kind = DK_FAULT; size = PG_4K; end
    endcase
  end

  assign attr = attr_lvl2(desc);
  assign pa   = merge_pa(desc, va, size);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_va,
  output logic              req_ready,
  input  logic [AW-1:0]     tbl_base,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [AW-1:0]     mem_rsp_data,
  output logic              res_valid,
  output logic [AW-1:0]     res_pa,
  output logic [SZ_W-1:0]   res_size,
  output logic              res_endian,
  output logic [ELEM_W-1:0] res_elem,
  output logic              res_mixed,
  output logic              fault_valid,
  output logic [AW-1:0]     fault_va,
  output logic [1:0]        fault_stat,
  input  logic              fault_ack
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_FAULT
  } state_e;

  state_e state;
  word_t  va_q, base_q, l2a_q;
  attr_t  attr_q;
  pgsz_e  size_q;

  dkind_e k1, k2;
  pgsz_e  s1, s2;
  attr_t  a1, a2;
  word_t  pa1, pa2, nxt1;

  xw_l1_decode u_l1 (
    .desc(mem_rsp_data), .va(va_q), .kind(k1), .size(s1),
    .attr(a1), .pa(pa1), .next_addr(nxt1)
  );

  xw_l2_decode u_l2 (
    .desc(mem_rsp_data), .va(va_q), .kind(k2), .size(s2),
    .attr(a2), .pa(pa2)
  );

  // named events for the checker
  logic ev_accept, ev_l1_rsp, ev_l2_rsp, ev_final_rsp;
  assign ev_accept    = req_valid && (state == ST_IDLE);
  assign ev_l1_rsp    = mem_rsp_valid && (state == ST_L1_WAIT);
  assign ev_l2_rsp    = mem_rsp_valid && (state == ST_L2_WAIT);
  assign ev_final_rsp = ev_l2_rsp || (ev_l1_rsp && (k1 != DK_TABLE));

  assign req_ready = (state == ST_IDLE);
  assign mem_req   = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign mem_addr  = (state == ST_L2_REQ) ? l2a_q : l1_addr(base_q, va_q);

  assign res_size   = size_q;
  assign res_endian = attr_q.endian;
  assign res_elem   = attr_q.elem;
  assign res_mixed  = attr_q.mixed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      va_q        <= '0;
      base_q      <= '0;
      l2a_q       <= '0;
      res_valid   <= 1'b0;
      res_pa      <= '0;
      size_q      <= PG_4K;
      attr_q      <= '0;
      fault_valid <= 1'b0;
      fault_va    <= '0;
      fault_stat  <= FS_NONE;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          va_q   <= req_va;
          base_q <= tbl_base;
          state  <= ST_L1_REQ;
        end
        ST_L1_REQ: state <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          unique case (k1)
            DK_LEAF: begin
              res_valid <= 1'b1;
              res_pa    <= pa1;
              size_q    <= s1;
              attr_q    <= a1;
              state     <= ST_IDLE;
            end
            DK_TABLE: begin
              l2a_q <= nxt1;
              state <= ST_L2_REQ;
            end
            default: begin
              fault_valid <= 1'b1;
              fault_va    <= va_q;
              fault_stat  <= FS_LVL1;
              state       <= ST_FAULT;
            end
          endcase
        end
        ST_L2_REQ: state <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid) begin
          if (k2 == DK_LEAF) begin
            res_valid <= 1'b1;
            res_pa    <= pa2;
            size_q    <= s2;
            attr_q    <= a2;
            state     <= ST_IDLE;
          end else begin
            fault_valid <= 1'b1;
            fault_va    <= va_q;
            fault_stat  <= FS_LVL2;
            state       <= ST_FAULT;
          end
        end
        ST_FAULT: if (fault_ack) begin
          fault_valid <= 1'b0;
          fault_stat  <= FS_NONE;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk
  import xw_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          res_valid,
  input logic          fault_valid,
  input logic [AW-1:0] fault_va,
  input logic [1:0]    fault_stat,
  input logic          fault_ack,
  input logic          ev_accept,
  input logic          ev_final_rsp
);
  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_word_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);

  assert_no_read_when_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !fault_ack) |=> (fault_valid && $stable(fault_va) && $stable(fault_stat)));

  assert_fault_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_ack) |=> !fault_valid);

  assert_res_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && fault_valid));

  assert_outcome_due_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_final_rsp |=> $countones({res_valid, $rose(fault_valid)}) == 1);
endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
  .mem_addr(mem_addr), .res_valid(res_valid), .fault_valid(fault_valid),
  .fault_va(fault_va), .fault_stat(fault_stat), .fault_ack(fault_ack),
  .ev_accept(ev_accept), .ev_final_rsp(ev_final_rsp)
);

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready;
  logic [31:0] tbl_base = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic [31:0] res_pa;
  logic [1:0]  res_size;
  logic        res_endian;
  logic [1:0]  res_elem;
  logic        res_mixed;
  logic        fault_valid;
  logic [31:0] fault_va;
  logic [1:0]  fault_stat;
  logic        fault_ack = 1'b0;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  xlat_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_ready(req_ready), .tbl_base(tbl_base), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_pa(res_pa),
    .res_size(res_size), .res_endian(res_endian), .res_elem(res_elem),
    .res_mixed(res_mixed), .fault_valid(fault_valid), .fault_va(fault_va),
    .fault_stat(fault_stat), .fault_ack(fault_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  // keep the top (32-sh) bits of d and the low sh bits of v
  function automatic logic [31:0] join_pa(input logic [31:0] d, input logic [31:0] v,
                                          input int sh);
    return ((d >> sh) << sh) | ((v << (32 - sh)) >> (32 - sh));
  endfunction

  task automatic respond(input logic [31:0] d, input int lat);
    repeat (lat) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = d;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
  endtask

  task automatic check_fault(input logic [31:0] va, input logic [31:0] st, input string req);
    eq(req, {31'd0, fault_valid}, 32'd1);
    eq(req, fault_va, va);
    eq(req, {30'd0, fault_stat}, st);
    eq("R9 no result on fault", {31'd0, res_valid}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    eq("R9 fault held", {31'd0, fault_valid}, 32'd1);
    eq("R10 busy while fault held", {31'd0, req_ready}, 32'd0);
    fault_ack = 1'b1;
    @(negedge clk);
    fault_ack = 1'b0;
    eq("R9 fault cleared by ack", {31'd0, fault_valid}, 32'd0);
    eq("R10 ready after ack", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input logic [31:0] d1, input logic [31:0] d2,
                      input int lat, input bit hammer);
    logic [31:0] e1, e2, epa;
    int sh;
    logic [31:0] esz;
    logic [3:0]  eat;
    bit leaf;
    e1 = {base[31:14], 14'd0} + (va >> 20) * 4;
    eq("R10 ready when idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1;
    req_va    = va;
    tbl_base  = base;
    @(negedge clk);
    req_valid = hammer;
    req_va    = ~va;
    tbl_base  = ~base;
    eq("R2 first read request", {31'd0, mem_req}, 32'd1);
    eq("R2 first read address", mem_addr, e1);
    eq("R10 busy after accept", {31'd0, req_ready}, 32'd0);
    leaf = 1'b0;
    if (d1[1:0] == 2'd2) begin
      leaf = 1'b1;
      if (d1[18]) begin sh = 24; esz = 32'd3; end
      else        begin sh = 20; esz = 32'd2; end
      eat = {d1[15], d1[11:10], d1[17]};
    end
    if (d1[1:0] != 2'd1) begin
      repeat (lat) @(negedge clk);
      eq("R10 no extra read while waiting", {31'd0, mem_req}, 32'd0);
      req_valid = 1'b0;
      respond(d1, 0);
      if (leaf) begin
        epa = join_pa(d1, va, sh);
        eq(d1[18] ? "R4 pulse" : "R3 pulse", {31'd0, res_valid}, 32'd1);
        eq(d1[18] ? "R4 supersection pa" : "R3 section pa", res_pa, epa);
        eq(d1[18] ? "R4 size" : "R3 size", {30'd0, res_size}, esz);
        eq("R5 level-1 attributes", {28'd0, res_endian, res_elem, res_mixed}, {28'd0, eat});
        @(negedge clk);
        eq("R11 pulse ends", {31'd0, res_valid}, 32'd0);
        eq("R10 ready after result", {31'd0, req_ready}, 32'd1);
      end else begin
        check_fault(va, 32'd1, "R9 level-1 fault");
      end
    end else begin
      respond(d1, lat);
      e2 = {d1[31:10], 10'd0} + ((va >> 12) & 32'hFF) * 4;
      eq("R6 second read request", {31'd0, mem_req}, 32'd1);
      eq("R6 second read address", mem_addr, e2);
      repeat (lat) @(negedge clk);
      eq("R10 no extra read while waiting", {31'd0, mem_req}, 32'd0);
      req_valid = 1'b0;
      respond(d2, 0);
      if (d2[1:0] == 2'd2 || d2[1:0] == 2'd1) begin
        sh  = (d2[1:0] == 2'd2) ? 12 : 16;
        esz = (d2[1:0] == 2'd2) ? 32'd0 : 32'd1;
        epa = join_pa(d2, va, sh);
        eq("R7 pulse", {31'd0, res_valid}, 32'd1);
        eq("R7 page pa", res_pa, epa);
        eq("R7 size", {30'd0, res_size}, esz);
        eq("R8 level-2 attributes", {28'd0, res_endian, res_elem, res_mixed},
           {28'd0, d2[9], d2[5:4], d2[11]});
        eq("R11 no fault with result", {31'd0, fault_valid}, 32'd0);
        @(negedge clk);
        eq("R11 pulse ends", {31'd0, res_valid}, 32'd0);
        eq("R10 ready after result", {31'd0, req_ready}, 32'd1);
      end else begin
        check_fault(va, 32'd2, "R9 level-2 fault");
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] vas [4];
    int k;
    vas[0] = 32'h0000_0000;
    vas[1] = 32'hFFFF_FFFF;
    vas[2] = 32'h1234_5678;
    vas[3] = 32'hA5F0_3C96;
    repeat (3) @(negedge clk);
    eq("R1 ready in reset", {31'd0, req_ready}, 32'd1);
    eq("R1 no read in reset", {31'd0, mem_req}, 32'd0);
    eq("R1 no result in reset", {31'd0, res_valid}, 32'd0);
    eq("R1 no fault in reset", {31'd0, fault_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    eq("R1 ready after reset", {31'd0, req_ready}, 32'd1);
    k = 0;
    for (int vi = 0; vi < 4; vi++) begin
      for (int t1 = 0; t1 < 4; t1++) begin
        for (int b18 = 0; b18 < 2; b18++) begin
          for (int t2 = 0; t2 < 4; t2++) begin
            logic [31:0] h, d1, d2, base;
            if (t1 != 1 && t2 != 0) continue;
            k++;
            h    = vas[vi] * 32'h9E37_79B1 + k * 32'h7F4A_7C15;
            base = h ^ 32'h5A5A_3FFF;
            d1   = {h[31:19], b18[0], h[17:2], t1[1:0]};
            d2   = {~h[31:2], t2[1:0]};
            walk(vas[vi], base, d1, d2, 1 + (k % 3), k[0]);
          end
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule